// File: doc/BRIEF.md
# Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands and returns their full-width signed product one clock after a valid strobe. The multiplier operand is scanned in overlapping three-bit windows. Each window becomes one signed digit in the range -2 to +2, carried as a small code with a unit flag, a double flag and a negate flag. Each digit picks a row of 0, ±Y or ±2Y, where Y is the multiplicand. The rows are weighted by powers of four, added together, and a final adder folds in the +1 corrections for the negated rows.

A zero is placed below the multiplier's least significant bit before the windows are formed. When the operand width is odd, the multiplier is sign-extended by one bit so that the windows tile it exactly. The number of rows is therefore half the (even) scanned width. A single output register holds the product, and it loads only when the valid input is high.

Top module: `booth_r4_mul`

## Requirements
- R1: When `inValid` is high at a rising edge, `product` equals the signed product `mcand * mplier` (2*WIDTH bits, two's complement) after that edge, and `outValid` is high.
- R2: When `inValid` is low at a rising edge, `outValid` is low after that edge and `product` keeps its previous value, whatever the operand inputs do.
- R3: While `rst_n` is low, `outValid` reads 0 and `product` reads 0.
- R4: Each window (b2,b1,b0) is taken as digit -2*b2 + b1 + b0, and windows 000 and 111 contribute nothing. A multiplier of all ones (every window 111 except the lowest) therefore yields `-mcand`, and alternating bit patterns (every window giving ±1 or ±2) yield the exact product.
- R5: The most negative operand times itself gives +2^(2*WIDTH-2), and the most negative times the most positive gives the exact negative product, with no overflow in 2*WIDTH bits.
- R6: 34 times -42 gives -1428.
- R7: For an odd WIDTH the multiplier is sign-extended by one bit before scanning, and every operand pair still gives the exact product.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands are valid this cycle |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier, Booth-recoded |
| outValid | output | 1 | Product register holds a new result |
| product | output | 2*WIDTH | Signed product |

## Verification
The bench builds two copies of the block side by side. One uses WIDTH=16, which is eight digit rows, and covers the directed cases: the worked example, all-ones and alternating multipliers, the extreme operands and idle gaps with operands still moving, followed by a random stream. The other uses WIDTH=7, where the multiplier must be sign-extended to eight bits. At that size all 16,384 operand pairs can be swept, so every window code reaches every row position, including the top row built from the extension bit.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // One signed radix-4 digit: magnitude 1, magnitude 2, and sign
  typedef struct packed {
    logic one;
    logic two;
    logic neg;
  } boothCode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;
  } ctrlStrobe_t;
endpackage

// File: rtl/booth_digit_enc.sv
module booth_digit_enc
  import booth_pkg::*;
(
  input  logic [2:0] grp,
  output boothCode_t code
);
  logic hiBit, midBit, loBit;

  assign hiBit  = grp[2];
  assign midBit = grp[1];
  assign loBit  = grp[0];

  // digit = -2*hi + mid + lo
  always_comb begin
    code.one = midBit ^ loBit;
    code.two = (hiBit & ~midBit & ~loBit) | (~hiBit & midBit & loBit);
    code.neg = hiBit & ~(midBit & loBit);
  end
endmodule

// File: rtl/booth_ctrl.sv
module booth_ctrl
  import booth_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);
  assign strobe.capture = inValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end
endmodule

// File: rtl/booth_datapath.sv
module booth_datapath
  import booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  ctrlStrobe_t               strobe,
  input  logic signed [WIDTH-1:0]   mcand,
  input  logic signed [WIDTH-1:0]   mplier,
  output logic signed [2*WIDTH-1:0] product
);
  localparam int EXTW = WIDTH + (WIDTH % 2);
  localparam int NDIG = EXTW / 2;
  localparam int PW   = 2 * WIDTH;

  logic signed [EXTW-1:0] mplierExt;
  logic [EXTW:0]          scanVec;
  logic signed [PW-1:0]   mcandExt;
  boothCode_t             code [NDIG];

  assign mplierExt = EXTW'(mplier);
  assign scanVec   = {mplierExt, 1'b0};
  assign mcandExt  = PW'(mcand);

  genvar gi;
  generate
    for (gi = 0; gi < NDIG; gi++) begin : g_digit
      booth_digit_enc u_enc (
        .grp  (scanVec[2*gi+2 : 2*gi]),
        .code (code[gi])
      );
    end
  endgenerate

  logic [PW-1:0] rowSum;
  logic [PW-1:0] fixVec;
  logic [PW-1:0] mag;
  logic [PW-1:0] row;
  logic [PW-1:0] sumNext;

  always_comb begin
    rowSum = '0;
    fixVec = '0;
    mag    = '0;
    row    = '0;
    for (int i = 0; i < NDIG; i++) begin
      if (code[i].two)      mag = mcandExt << 1;
      else if (code[i].one) mag = mcandExt;
      else                  mag = '0;
      row    = code[i].neg ? ~mag : mag;
      rowSum = rowSum + (row << (2 * i));
      fixVec[2*i] = code[i].neg;
    end
    sumNext = rowSum + fixVec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              product <= '0;
    else if (strobe.capture) product <= sumNext;
  end
endmodule

// File: rtl/booth_r4_mul.sv
module booth_r4_mul
  import booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      inValid,
  input  logic signed [WIDTH-1:0]   mcand,
  input  logic signed [WIDTH-1:0]   mplier,
  output logic                      outValid,
  output logic signed [2*WIDTH-1:0] product
);
  ctrlStrobe_t strobe;

  booth_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  booth_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .mcand   (mcand),
    .mplier  (mplier),
    .product (product)
  );
endmodule

// File: rtl/booth_r4_mul_chk.sv
module booth_r4_mul_chk #(
  parameter int WIDTH = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      inValid,
  input logic signed [WIDTH-1:0]   mcand,
  input logic signed [WIDTH-1:0]   mplier,
  input logic                      outValid,
  input logic signed [2*WIDTH-1:0] product
);
  logic signed [2*WIDTH-1:0] refProd;
  assign refProd = mcand * mplier;

  // R1
  prod_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> (product == $past(refProd)));

  // R1
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R2
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R2
  prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(product));
endmodule

bind booth_r4_mul booth_r4_mul_chk #(.WIDTH(WIDTH)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .mcand    (mcand),
  .mplier   (mplier),
  .outValid (outValid),
  .product  (product)
);

// File: tb/booth_r4_mul_tb.sv
module booth_r4_mul_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 16;
  localparam int NW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic                   inV  = 1'b0;
  logic signed [W-1:0]    a    = '0;
  logic signed [W-1:0]    b    = '0;
  logic                   outV;
  logic signed [2*W-1:0]  prod;

  logic                   inVn = 1'b0;
  logic signed [NW-1:0]   an   = '0;
  logic signed [NW-1:0]   bn   = '0;
  logic                   outVn;
  logic signed [2*NW-1:0] prodn;

  booth_r4_mul #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .inValid(inV), .mcand(a), .mplier(b),
    .outValid(outV), .product(prod));

  booth_r4_mul #(.WIDTH(NW)) dut7_i (
    .clk(clk), .rst_n(rst_n), .inValid(inVn), .mcand(an), .mplier(bn),
    .outValid(outVn), .product(prodn));

  int checks = 0;
  int fails  = 0;
  bit running = 1'b0;
  string tag  = "R1";
  string tagQ = "R1";

  // behavioural reference, one register deep
  logic                   expV  = 1'b0;
  logic signed [2*W-1:0]  expP  = '0;
  logic                   expVn = 1'b0;
  logic signed [2*NW-1:0] expPn = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      expV <= 1'b0; expP <= '0; expVn <= 1'b0; expPn <= '0;
    end else begin
      expV  <= inV;
      expVn <= inVn;
      tagQ  <= inV ? tag : "R2";
      if (inV)  expP  <= longint'(a) * longint'(b);
      if (inVn) expPn <= longint'(an) * longint'(bn);
    end
  end

  task automatic check(string req, longint act, longint exp_v, string what);
    checks++;
    if (act != exp_v) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      check(tagQ, longint'(prod), longint'(expP), "product w16");
      check(tagQ == "R2" ? "R2" : "R1", longint'(outV), longint'(expV), "outValid w16");
      check("R7", longint'(prodn), longint'(expPn), "product w7");
      check("R7", longint'(outVn), longint'(expVn), "outValid w7");
    end
  end

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  task automatic drive(logic v, logic signed [W-1:0] x, logic signed [W-1:0] y, string t);
    @(negedge clk);
    inV = v; a = x; b = y; tag = t;
  endtask

  initial begin
    // R3: reset state, with operands moving
    inV = 1'b1; a = 16'sd123; b = -16'sd7;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3", longint'(outV), 0, "outValid in reset");
    check("R3", longint'(prod), 0, "product in reset");
    check("R3", longint'(outVn), 0, "outValid w7 in reset");
    check("R3", longint'(prodn), 0, "product w7 in reset");
    inV = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    running = 1'b1;

    drive(1'b1, 16'sd34, -16'sd42, "R6");
    drive(1'b1, 16'sd1234, -16'sd1, "R4");
    drive(1'b1, -16'sd999, -16'sd1, "R4");
    drive(1'b1, 16'sd3001, 16'sh5555, "R4");
    drive(1'b1, -16'sd77, 16'shAAAA, "R4");
    drive(1'b1, 16'sh7FFF, 16'sh3333, "R4");
    drive(1'b1, 16'sh8000, 16'sh8000, "R5");
    drive(1'b1, 16'sh8000, 16'sh7FFF, "R5");
    drive(1'b1, 16'sh7FFF, 16'sh7FFF, "R5");
    // R2: idle with operands changing, product must hold
    for (int k = 0; k < 6; k++) drive(1'b0, W'($urandom), W'($urandom), "R2");
    drive(1'b1, 16'sd0, 16'sh8000, "R1");
    drive(1'b0, 16'sd5, 16'sd5, "R2");

    // random stream on the wide copy, exhaustive sweep on the odd-width copy
    for (int x = -64; x < 64; x++) begin
      for (int y = -64; y < 64; y++) begin
        @(negedge clk);
        inVn = ((x + y) % 5) != 0;
        an = NW'(x); bn = NW'(y);
        inV = ($urandom % 4) != 0;
        a = W'($urandom); b = W'($urandom);
        tag = "R1";
      end
    end
    @(negedge clk);
    inV = 1'b0; inVn = 1'b0;
    repeat (3) @(negedge clk);
    running = 1'b0;
    finishRun();
  end
endmodule